// File: doc/BRIEF.md
# ADC Conversion Sequencer with Priority Preemption

This block drives an eight-channel successive-approximation converter. It chooses the channel and signals the start of each conversion. It times every conversion and captures the converter's result when the conversion ends. A normal request converts one channel, or a contiguous ascending range of channels. In repeat mode it loops over that range. A result strobe for the converted channel goes with each captured value, and a normal interrupt pulse marks the end of each single conversion or each completed pass.

A priority request may arrive at any moment. It cancels the normal conversion in flight and throws that conversion's partial result away. It then converts its own channel, reports through a separate strobe and interrupt, and resumes the normal sequence on the channel that was cancelled. A priority request that arrives while another priority conversion is running has no effect. Each conversion lasts 46 ticks of a conversion clock. That clock is the system clock divided by 1, 2, 4 or 8.

The controller has three states: `ST_IDLE`, `ST_NORM` (a normal conversion is running) and `ST_PRIO` (a priority conversion is running). Its transitions are:
- idle-to-norm on `start`.
- idle-to-prio on `hp_req`.
- norm-to-norm when a conversion ends and the pass continues or repeats.
- norm-to-idle when the final conversion of a pass ends and repeat is off.
- norm-to-prio on `hp_req`, which aborts the current conversion.
- prio-to-norm when the priority conversion ends after an abort.
- prio-to-idle when the priority conversion ends and it was launched from idle.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the block is idle. All strobes, interrupts, `adc_sample`, `adc_busy` and `hp_busy` are low.
- R2: The block accepts a conversion on a clock edge. Its result strobe appears exactly 46×2^`clk_div_sel` cycles after that edge (`clk_div_sel` values 0, 1, 2 and 3 give divides of 1, 2, 4 and 8). The next conversion of a sequence is accepted on the same edge that produces the strobe.
- R3: With `scan_en`=0, a `start` converts `first_ch` once. Bit `first_ch` of `res_we` pulses for one cycle, with the converter value on `res_data` and `norm_irq` high in the same cycle. The block then returns to idle.
- R4: With `scan_en`=1 and `first_ch`≤`last_ch`, the block converts channels `first_ch` through `last_ch` in ascending order, back to back. `norm_irq` pulses only together with the strobe of `last_ch`.
- R5: With `repeat_en`=1, the pass restarts at `first_ch` right after `last_ch`. `repeat_en` is sampled at each pass end, so clearing it lets the current pass finish and then the block goes idle.
- R6: `hp_req` with channel `hp_ch` aborts a normal conversion in flight, even one in its final cycle, and produces no strobe for it. One conversion later, `hp_we` and `hp_irq` pulse together, with the `hp_ch` value on `res_data`.
- R7: After a priority conversion that aborted a normal one, the normal conversion restarts on the aborted channel and the pass continues to its end.
- R8: An `hp_req` that arrives while `hp_busy` is high is ignored. The running conversion keeps its channel and timing.
- R9: A priority conversion launched from idle returns to idle and produces no normal strobe. A `start` that arrives while busy is ignored, and the channel range stays as it was latched at the accepted start.
- R10: `adc_sample` is high for the first cycle of every conversion, with `adc_ch` showing the channel being converted. At most one bit of `res_we` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div_sel | input | 2 | Conversion clock divide select (2^value) |
| start | input | 1 | One-cycle request to begin a normal sequence |
| scan_en | input | 1 | 1: convert a channel range, 0: a single channel |
| repeat_en | input | 1 | Loop the sequence while high |
| first_ch | input | 3 | Lowest channel of the range (the single channel when not scanning) |
| last_ch | input | 3 | Highest channel of the range |
| hp_req | input | 1 | One-cycle priority conversion request |
| hp_ch | input | 3 | Channel for the priority conversion |
| adc_sample | output | 1 | First cycle of a conversion |
| adc_ch | output | 3 | Channel currently driven to the converter |
| adc_data | input | 10 | Converter output value |
| adc_busy | output | 1 | A conversion is running |
| hp_busy | output | 1 | A priority conversion is running |
| res_we | output | 8 | One-hot per-channel normal result strobe |
| hp_we | output | 1 | Priority result strobe |
| res_data | output | 10 | Value captured at the last strobe |
| norm_irq | output | 1 | End of a single conversion or of a pass |
| hp_irq | output | 1 | End of a priority conversion |

## Verification
A normal start sampled on edge t0 leads to result i of the pass on edge t0+(i+1)·N, where N=46·2^`clk_div_sel`. A priority request sampled on edge th produces its strobe at th+N. The aborted channel j then strobes at th+N+(j−k+1)·N, where k is the channel index that was cancelled. The bench records the cycle number of every strobe. It then compares the recorded list with a list built from these formulas, so every result is checked on its exact cycle and channel. `adc_sample` and `adc_ch` are checked on the negative edge right after the accepting edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_PRIO = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int SEL_W = 2,
    localparam int CNT_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'((32'd1 << sel) - 32'd1);
    assign tick = en && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int TICKS = 46,
    localparam int TW = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);

    logic [TW-1:0] tcnt;

    assign done = tick && (tcnt == TW'(TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (clr) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= done ? '0 : tcnt + TW'(1);
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              scan_en,
    input  logic              repeat_en,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    input  logic              hp_req,
    input  logic [CH_W-1:0]   hp_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              restart,
    output logic              busy,
    output logic              prio_busy,
    output logic [CH_W-1:0]   conv_ch,
    output logic              sample_o,
    output logic              norm_we,
    output logic [CH_W-1:0]   we_ch,
    output logic              prio_we,
    output logic [DATA_W-1:0] data_o,
    output logic              norm_irq,
    output logic              prio_irq
);

    seq_state_e state, state_nx;

    logic [CH_W-1:0] cur_ch;
    logic [CH_W-1:0] lo_q;
    logic [CH_W-1:0] hi_q;
    logic            scan_q;
    logic [CH_W-1:0] prio_ch_q;
    logic            resume_q;

    logic prio_go;
    logic norm_fin;
    logic prio_fin;
    logic pass_last;
    logic accept_start;

    assign prio_go      = hp_req && (state != ST_PRIO);
    assign accept_start = (state == ST_IDLE) && start && !hp_req;
    assign norm_fin     = (state == ST_NORM) && conv_done && !hp_req;
    assign prio_fin     = (state == ST_PRIO) && conv_done;
    assign pass_last    = !scan_q || (cur_ch == hi_q);

    assign busy      = (state != ST_IDLE);
    assign prio_busy = (state == ST_PRIO);
    assign conv_ch   = (state == ST_PRIO) ? prio_ch_q : cur_ch;

    // next state and conversion (re)start
    always_comb begin
        state_nx = state;
        restart  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (prio_go) begin
                    state_nx = ST_PRIO;
                    restart  = 1'b1;
                end else if (start) begin
                    state_nx = ST_NORM;
                    restart  = 1'b1;
                end
            end
            ST_NORM: begin
                if (prio_go) begin
                    state_nx = ST_PRIO;
                    restart  = 1'b1;
                end else if (norm_fin) begin
                    if (pass_last && !repeat_en) begin
                        state_nx = ST_IDLE;
                    end else begin
                        restart = 1'b1;
                    end
                end
            end
            ST_PRIO: begin
                if (prio_fin) begin
                    if (resume_q) begin
                        state_nx = ST_NORM;
                        restart  = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch    <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            scan_q    <= 1'b0;
            prio_ch_q <= '0;
            resume_q  <= 1'b0;
        end else begin
            if (accept_start) begin
                lo_q   <= first_ch;
                hi_q   <= last_ch;
                scan_q <= scan_en;
                cur_ch <= first_ch;
            end
            if (prio_go) begin
                prio_ch_q <= hp_ch;
                resume_q  <= (state == ST_NORM);
            end
            if (norm_fin) begin
                cur_ch <= pass_last ? lo_q : cur_ch + CH_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o <= 1'b0;
            norm_we  <= 1'b0;
            we_ch    <= '0;
            prio_we  <= 1'b0;
            data_o   <= '0;
            norm_irq <= 1'b0;
            prio_irq <= 1'b0;
        end else begin
            sample_o <= restart;
            norm_we  <= norm_fin;
            prio_we  <= prio_fin;
            norm_irq <= norm_fin && pass_last;
            prio_irq <= prio_fin;
            if (norm_fin) begin
                we_ch <= cur_ch;
            end
            if (norm_fin || prio_fin) begin
                data_o <= adc_data;
            end
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int N_CH       = 8,
    parameter int DATA_W     = 10,
    parameter int SEL_W      = 2,
    parameter int CONV_TICKS = 46,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  clk_div_sel,
    input  logic              start,
    input  logic              scan_en,
    input  logic              repeat_en,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    input  logic              hp_req,
    input  logic [CH_W-1:0]   hp_ch,
    output logic              adc_sample,
    output logic [CH_W-1:0]   adc_ch,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_busy,
    output logic              hp_busy,
    output logic [N_CH-1:0]   res_we,
    output logic              hp_we,
    output logic [DATA_W-1:0] res_data,
    output logic              norm_irq,
    output logic              hp_irq
);

    logic            restart;
    logic            tick;
    logic            conv_done;
    logic            norm_we;
    logic [CH_W-1:0] we_ch;

    adc_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (adc_busy),
        .sel   (clk_div_sel),
        .tick  (tick)
    );

    adc_conv_timer #(.TICKS(CONV_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick),
        .done  (conv_done)
    );

    adc_seq_fsm #(.CH_W(CH_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .scan_en   (scan_en),
        .repeat_en (repeat_en),
        .first_ch  (first_ch),
        .last_ch   (last_ch),
        .hp_req    (hp_req),
        .hp_ch     (hp_ch),
        .conv_done (conv_done),
        .adc_data  (adc_data),
        .restart   (restart),
        .busy      (adc_busy),
        .prio_busy (hp_busy),
        .conv_ch   (adc_ch),
        .sample_o  (adc_sample),
        .norm_we   (norm_we),
        .we_ch     (we_ch),
        .prio_we   (hp_we),
        .data_o    (res_data),
        .norm_irq  (norm_irq),
        .prio_irq  (hp_irq)
    );

    // per-channel strobe decode
    for (genvar g = 0; g < N_CH; g++) begin : g_we
        assign res_we[g] = norm_we && (we_ch == CH_W'(g));
    end

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int N_CH       = 8,
    parameter int SEL_W      = 2,
    parameter int CONV_TICKS = 46,
    localparam int CH_W = $clog2(N_CH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] clk_div_sel,
    input logic             adc_sample,
    input logic [CH_W-1:0]  adc_ch,
    input logic             adc_busy,
    input logic             hp_busy,
    input logic [N_CH-1:0]  res_we,
    input logic             hp_we,
    input logic             norm_irq
);

    logic [15:0] len_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_cnt <= '0;
        end else if (adc_sample) begin
            len_cnt <= 16'd1;
        end else if (adc_busy) begin
            len_cnt <= len_cnt + 16'd1;
        end
    end

    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|res_we) || hp_we) |-> (len_cnt == (16'(CONV_TICKS) << clk_div_sel)));

    p_onehot_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_we));

    p_sample_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sample |-> adc_busy);

    p_irq_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        norm_irq |-> (|res_we));

    p_abort_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_busy) |-> (res_we == '0));

    p_hp_after_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hp_we |-> $past(hp_busy));

    p_hp_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_busy && $past(hp_busy)) |-> $stable(adc_ch));

    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hp_busy) && adc_busy) |-> adc_sample);

endmodule

bind adc_seq_top adc_seq_checker #(
    .N_CH       (N_CH),
    .SEL_W      (SEL_W),
    .CONV_TICKS (CONV_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_div_sel (clk_div_sel),
    .adc_sample  (adc_sample),
    .adc_ch      (adc_ch),
    .adc_busy    (adc_busy),
    .hp_busy     (hp_busy),
    .res_we      (res_we),
    .hp_we       (hp_we),
    .norm_irq    (norm_irq)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_div_sel = '0;
    logic       start = 1'b0;
    logic       scan_en = 1'b0;
    logic       repeat_en = 1'b0;
    logic [2:0] first_ch = '0;
    logic [2:0] last_ch = '0;
    logic       hp_req = 1'b0;
    logic [2:0] hp_ch = '0;
    logic       adc_sample;
    logic [2:0] adc_ch;
    logic [9:0] adc_data;
    logic       adc_busy;
    logic       hp_busy;
    logic [7:0] res_we;
    logic       hp_we;
    logic [9:0] res_data;
    logic       norm_irq;
    logic       hp_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] stub_val(input int ch);
        return 10'((ch * 97 + 13) & 32'h3ff);
    endfunction

    assign adc_data = stub_val(int'(adc_ch));

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel), .start(start),
        .scan_en(scan_en), .repeat_en(repeat_en), .first_ch(first_ch),
        .last_ch(last_ch), .hp_req(hp_req), .hp_ch(hp_ch),
        .adc_sample(adc_sample), .adc_ch(adc_ch), .adc_data(adc_data),
        .adc_busy(adc_busy), .hp_busy(hp_busy), .res_we(res_we), .hp_we(hp_we),
        .res_data(res_data), .norm_irq(norm_irq), .hp_irq(hp_irq)
    );

    // event log
    int ev_n = 0;
    int ev_cyc [0:63];
    int ev_kind[0:63];
    int ev_ch  [0:63];
    int ev_dat [0:63];
    int ev_irq [0:63];
    int ex_n = 0;
    int ex_cyc [0:63];
    int ex_kind[0:63];
    int ex_ch  [0:63];
    int ex_irq [0:63];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && (|res_we)) begin
            check($countones(res_we) == 1, "R10", "res_we bits", $countones(res_we), 1);
            if (ev_n < 64) begin
                ev_cyc[ev_n] = cyc;  ev_kind[ev_n] = 0;
                ev_ch[ev_n] = 0;
                for (int b = 7; b >= 0; b--) if (res_we[b]) ev_ch[ev_n] = b;
                ev_dat[ev_n] = int'(res_data); ev_irq[ev_n] = int'(norm_irq);
            end
            ev_n++;
        end
        if (rst_n && hp_we) begin
            if (ev_n < 64) begin
                ev_cyc[ev_n] = cyc;  ev_kind[ev_n] = 1; ev_ch[ev_n] = -1;
                ev_dat[ev_n] = int'(res_data); ev_irq[ev_n] = int'(hp_irq);
            end
            ev_n++;
        end
    end

    task automatic add_ex(input int c, input int k, input int ch, input int irq);
        ex_cyc[ex_n] = c; ex_kind[ex_n] = k; ex_ch[ex_n] = ch; ex_irq[ex_n] = irq;
        ex_n++;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t - 1) @(negedge clk);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (adc_busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check(ev_n == ex_n, req, "event count", ev_n, ex_n);
        for (int i = 0; i < ex_n && i < ev_n; i++) begin
            string r;
            int expdat;
            r = (ex_kind[i] == 1) ? "R6" : req;
            expdat = int'(stub_val(ex_ch[i]));
            check(ev_cyc[i] == ex_cyc[i], r, "R2 strobe cycle", ev_cyc[i], ex_cyc[i]);
            check(ev_kind[i] == ex_kind[i], r, "strobe kind", ev_kind[i], ex_kind[i]);
            if (ex_kind[i] == 0)
                check(ev_ch[i] == ex_ch[i], r, "channel", ev_ch[i], ex_ch[i]);
            check(ev_dat[i] == expdat, r, "data", ev_dat[i], expdat);
            check(ev_irq[i] == ex_irq[i], r, "irq", ev_irq[i], ex_irq[i]);
        end
    endtask

    // normal sequence with optional preemption
    task automatic run_seq(input int sel, input int lo, input int hi, input bit scan,
                           input bit hp_on, input int k, input int off, input int hch,
                           input bit hp2, input int off2, input bit st2, input string req);
        int n, len, t0, th;
        n = 46 << sel;
        len = scan ? (hi - lo + 1) : 1;
        ev_n = 0; ex_n = 0;
        @(negedge clk);
        clk_div_sel = 2'(sel); first_ch = 3'(lo); last_ch = 3'(hi);
        scan_en = scan; repeat_en = 1'b0; start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        check(adc_sample && adc_busy && (int'(adc_ch) == lo), "R10", "sample at start",
              int'(adc_ch), lo);
        th = t0 + k * n + off;
        if (st2) begin
            wait_to(t0 + n / 2);
            first_ch = 3'((lo + 3) % 8); last_ch = 3'(7); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (hp_on) begin
            wait_to(th);
            hp_req = 1'b1; hp_ch = 3'(hch);
            @(negedge clk);
            hp_req = 1'b0;
            if (hp2) begin
                wait_to(th + off2);
                hp_req = 1'b1; hp_ch = 3'((hch + 1) % 8);
                @(negedge clk);
                hp_req = 1'b0;
            end
        end
        wait_idle();
        for (int i = 0; i < len; i++) begin
            if (!hp_on || i < k) add_ex(t0 + (i + 1) * n, 0, lo + i, (i == len - 1) ? 1 : 0);
        end
        if (hp_on) begin
            add_ex(th + n, 1, hch, 1);
            for (int j = k; j < len; j++)
                add_ex(th + n + (j - k + 1) * n, 0, lo + j, (j == len - 1) ? 1 : 0);
        end
        compare(req);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int t0, th, n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_we == 0 && !hp_we && !norm_irq && !hp_irq, "R1", "strobes in reset", int'(res_we), 0);
        check(!adc_busy && !hp_busy && !adc_sample, "R1", "busy in reset", int'(adc_busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!adc_busy && !hp_busy && res_we == 0, "R1", "idle after reset", int'(adc_busy), 0);

        // directed cases
        run_seq(0, 0, 0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, 1'b0, "R3");
        run_seq(1, 4, 6, 1'b1, 1'b1, 2, 30, 7, 1'b0, 0, 1'b0, "R7");
        run_seq(0, 2, 4, 1'b1, 1'b1, 1, 46, 5, 1'b0, 0, 1'b0, "R6");
        run_seq(2, 1, 3, 1'b1, 1'b1, 0, 5, 6, 1'b1, 100, 1'b0, "R8");
        run_seq(3, 0, 7, 1'b1, 1'b0, 0, 0, 0, 1'b0, 0, 1'b1, "R4");
        run_seq(1, 5, 5, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, 1'b1, "R9");

        // R5 repeat, cleared during the second pass
        ev_n = 0; ex_n = 0;
        n = 92;
        @(negedge clk);
        clk_div_sel = 2'd1; first_ch = 3'd2; last_ch = 3'd4;
        scan_en = 1'b1; repeat_en = 1'b1; start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        wait_to(t0 + 3 * n + 5);
        repeat_en = 1'b0;
        wait_idle();
        for (int i = 0; i < 6; i++) add_ex(t0 + (i + 1) * n, 0, 2 + (i % 3), (i % 3 == 2) ? 1 : 0);
        compare("R5");

        // R9 priority from idle
        ev_n = 0; ex_n = 0;
        @(negedge clk);
        clk_div_sel = 2'd0; hp_req = 1'b1; hp_ch = 3'd3;
        th = cyc + 1;
        @(negedge clk);
        hp_req = 1'b0;
        check(hp_busy && adc_sample && adc_ch == 3'd3, "R9", "priority from idle", int'(adc_ch), 3);
        wait_idle();
        add_ex(th + 46, 1, 3, 1);
        compare("R9");
        check(!adc_busy && !hp_busy, "R9", "idle after priority", int'(adc_busy), 0);

        // constrained random
        for (int it = 0; it < 14; it++) begin
            int sel, lo, hi, len, k, off, hch, off2, nn;
            bit scan, hp_on, hp2, st2;
            sel = int'($urandom % 4);
            lo = int'($urandom % 8);
            hi = lo + int'($urandom % (8 - lo));
            scan = ($urandom % 4) != 0;
            if (!scan) hi = lo;
            len = hi - lo + 1;
            hp_on = ($urandom % 3) != 0;
            nn = 46 << sel;
            k = int'($urandom % len);
            off = 1 + int'($urandom % nn);
            hch = int'($urandom % 8);
            hp2 = ($urandom % 2) != 0;
            off2 = 1 + int'($urandom % (nn - 1));
            st2 = !hp_on && (it % 2 == 1);
            run_seq(sel, lo, hi, scan, hp_on, k, off, hch, hp2, off2, st2,
                    hp_on ? "R7" : (scan ? "R4" : "R3"));
        end

        report();
        $finish;
    end

endmodule